// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a down-counting watchdog. It counts on a slow tick enable that comes in from outside and has no stop control. Software drives it through four 16-bit registers on a simple write/read bus: a key register, a divider-code register, a reload register and a status register. Magic values written to the key register do three things. One value starts the counter. One opens the two configuration registers for writing. One refreshes the counter and closes the configuration registers again.

A value written to a configuration register first lands in a shadow copy. It reaches the counting logic only after a fixed number of slow ticks. While that transfer is under way a busy flag is set, and any further write to that register is dropped. If the counter runs out, the block raises a reset request. The request stays high until the system reset clears the whole block. Software can force a quick reset on purpose: it loads a reload value of 1 and then refreshes.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the reset request is 0, the divider code reads 0, the reload register reads 0xFFF and the status register reads 0.
- R2: The registers sit at these addresses: 0 is the key register (reads 0), 1 is the divider code in bits 2:0, 2 is the reload value in bits 11:0, and 3 is the status register. In the status register, bit 0 means the divider update is busy and bit 1 means the reload update is busy. Key values: 0x5555 unlocks, 0xCCCC starts, 0xAAAA refreshes.
- R3: A write to the divider or reload register is ignored while they are locked. Any key write other than 0x5555 locks them again.
- R4: An accepted configuration write sets its busy bit. The bit clears once exactly SYNC_TICKS (default 5) slow ticks have been counted after the write cycle. Only then does the new value take effect.
- R5: A write to a configuration register while its busy bit is set is lost, and the register keeps its earlier value.
- R6: Once started, the block raises the reset request after max(R,1)·D slow ticks. D is 4·2^min(n,6), where n is the divider code and R is the reload value, both taken from the transferred values. Without a start the request never rises.
- R7: A refresh reloads the counter from the transferred reload value and clears the divider, which restarts the full timeout.
- R8: A refresh written in the same cycle as the tick that would expire the counter wins, so no reset request is raised.
- R9: The reset request stays high until the system reset, whatever keys are written afterwards.
- R10: Once started, the counter cannot be stopped by any key write.
- R11: With a transferred reload value of 1, a refresh followed by D slow ticks forces the reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| slow_tick | input | 1 | One-cycle enable from the slow time base |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| wdog_rst_req | output | 1 | Sticky reset request |

## Verification
Two functions can fall in the same cycle: the refresh key write and the slow tick that would take the counter to its end. The bench lines the refresh up with exactly the final tick of a known timeout. It then expects no request at that point, and a request again after one more full timeout counted from the refresh. A second overlap is a configuration write that arrives while a transfer is still pending. The bench judges this by reading back the shadow register and the busy bit.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PSC_W   = 3;
  localparam int RLD_W   = 12;
  localparam int DIV_W   = 9;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 2;
  localparam int BASE_LOG = 2;
  localparam int MAX_LOG  = 8;

  localparam logic [ADDR_W-1:0] A_KEY = 2'd0;
  localparam logic [ADDR_W-1:0] A_PSC = 2'd1;
  localparam logic [ADDR_W-1:0] A_RLD = 2'd2;
  localparam logic [ADDR_W-1:0] A_STS = 2'd3;

  localparam logic [DATA_W-1:0] K_UNLOCK  = 16'h5555;
  localparam logic [DATA_W-1:0] K_START   = 16'hCCCC;
  localparam logic [DATA_W-1:0] K_REFRESH = 16'hAAAA;

  // Slow ticks per count step for a divider code.
  function automatic logic [DIV_W-1:0] ticks_per_step(input logic [PSC_W-1:0] code);
    int sh;
    sh = BASE_LOG + int'(code);
    if (sh > MAX_LOG) sh = MAX_LOG;
    return DIV_W'(1) << sh;
  endfunction
endpackage

// File: rtl/wdt_key_ctrl.sv
module wdt_key_ctrl
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_val,
  output logic              running,
  output logic              unlocked,
  output logic              start_evt,
  output logic              refresh_evt
);
  assign start_evt   = key_wr && (key_val == K_START) && !running;
  assign refresh_evt = key_wr && (key_val == K_REFRESH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      unlocked <= 1'b0;
    end else if (key_wr) begin
      if (key_val == K_START) running <= 1'b1;
      unlocked <= (key_val == K_UNLOCK);
    end
  end
endmodule

// File: rtl/wdt_cfg_sync.sv
module wdt_cfg_sync #(
  parameter int W          = 12,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter int SYNC_TICKS = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         busy,
  output logic         accept
);
  localparam int SC_W = $clog2(SYNC_TICKS + 1);
  localparam logic [SC_W-1:0] SC_LOAD = SC_W'(SYNC_TICKS);

  logic [SC_W-1:0] left;

  assign accept = wr_en && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= RST_VAL;
      active <= RST_VAL;
      busy   <= 1'b0;
      left   <= '0;
    end else if (accept) begin
      shadow <= wdata;
      busy   <= 1'b1;
      left   <= SC_LOAD;
    end else if (busy && tick) begin
      left <= left - 1'b1;
      if (left == SC_W'(1)) begin
        active <= shadow;
        busy   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             reload_now,
  input  logic [RLD_W-1:0] reload_val,
  input  logic [PSC_W-1:0] psc_code,
  output logic             expired,
  output logic             step_evt
);
  logic [RLD_W-1:0] cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_last;
  logic             counting;

  assign div_last = ticks_per_step(psc_code) - 1'b1;
  assign counting = run && !expired && tick;
  assign step_evt = counting && (div_cnt >= div_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '1;
      div_cnt <= '0;
      expired <= 1'b0;
    end else if (reload_now) begin
      cnt     <= reload_val;
      div_cnt <= '0;
    end else if (counting) begin
      if (step_evt) begin
        div_cnt <= '0;
        if (cnt <= RLD_W'(1)) expired <= 1'b1;
        else cnt <= cnt - 1'b1;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int SYNC_TICKS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              wdog_rst_req
);
  logic running, unlocked, start_evt, refresh_evt;
  logic key_wr, psc_wr, rld_wr;
  logic psc_busy, rld_busy, psc_acc, rld_acc, step_evt, expired;
  logic [PSC_W-1:0] psc_shadow, psc_active;
  logic [RLD_W-1:0] rld_shadow, rld_active;

  assign key_wr = reg_wr && (reg_addr == A_KEY);
  assign psc_wr = reg_wr && (reg_addr == A_PSC) && unlocked;
  assign rld_wr = reg_wr && (reg_addr == A_RLD) && unlocked;

  wdt_key_ctrl u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_val(reg_wdata),
    .running(running), .unlocked(unlocked),
    .start_evt(start_evt), .refresh_evt(refresh_evt)
  );

  wdt_cfg_sync #(.W(PSC_W), .RST_VAL('0), .SYNC_TICKS(SYNC_TICKS)) u_psc (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .wr_en(psc_wr),
    .wdata(reg_wdata[PSC_W-1:0]), .shadow(psc_shadow), .active(psc_active),
    .busy(psc_busy), .accept(psc_acc)
  );

  wdt_cfg_sync #(.W(RLD_W), .RST_VAL('1), .SYNC_TICKS(SYNC_TICKS)) u_rld (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .wr_en(rld_wr),
    .wdata(reg_wdata[RLD_W-1:0]), .shadow(rld_shadow), .active(rld_active),
    .busy(rld_busy), .accept(rld_acc)
  );

  wdt_down_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .run(running),
    .reload_now(start_evt || refresh_evt), .reload_val(rld_active),
    .psc_code(psc_active), .expired(expired), .step_evt(step_evt)
  );

  assign wdog_rst_req = expired;

  always_comb begin
    unique case (reg_addr)
      A_PSC:   reg_rdata = DATA_W'(psc_shadow);
      A_RLD:   reg_rdata = DATA_W'(rld_shadow);
      A_STS:   reg_rdata = DATA_W'({rld_busy, psc_busy});
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
  import wdt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wdog_rst_req,
  input logic             running,
  input logic             refresh_evt,
  input logic             reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic             unlocked,
  input logic             psc_busy,
  input logic             rld_busy,
  input logic             psc_acc,
  input logic [PSC_W-1:0] psc_shadow,
  input logic [RLD_W-1:0] rld_shadow
);
  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_req |=> wdog_rst_req); // R9
  AST_REQ_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_req |-> running); // R6
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running); // R10
  AST_LOCKED_PSC: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_PSC && !unlocked) |=> $stable(psc_shadow)); // R3
  AST_LOCKED_RLD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_RLD && !unlocked) |=> $stable(rld_shadow)); // R3
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_RLD && rld_busy) |=> $stable(rld_shadow)); // R5
  AST_BUSY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    psc_acc |=> psc_busy); // R4
  AST_REFRESH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_evt && !wdog_rst_req) |=> !wdog_rst_req); // R8
endmodule

bind wdt_keyed wdt_keyed_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wdog_rst_req(wdog_rst_req), .running(running),
  .refresh_evt(refresh_evt), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .unlocked(unlocked), .psc_busy(psc_busy), .rld_busy(rld_busy),
  .psc_acc(psc_acc), .psc_shadow(psc_shadow), .rld_shadow(rld_shadow)
);

// File: tb/wdt_keyed_test.sv
`timescale 1ns/1ps
module wdt_keyed_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        wdog_rst_req;
  int checks = 0;
  int errors = 0;
  int seed_init;

  always #2 clk = ~clk;

  wdt_keyed uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wdog_rst_req(wdog_rst_req)
  );

  function automatic int div_of(input int code);
    case (code)
      0: return 4;   1: return 8;   2: return 16;  3: return 32;
      4: return 64;  5: return 128; default: return 256;
    endcase
  endfunction

  function automatic int timeout_of(input int r, input int code);
    return ((r == 0) ? 1 : r) * div_of(code);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 1'b0; slow_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output int d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
      repeat ($urandom % 3) @(negedge clk);
    end
  endtask

  task automatic configure(input int code, input int r);
    bus_wr(2'd0, 16'h5555);
    bus_wr(2'd1, 16'(code));
    bus_wr(2'd2, 16'(r));
    ticks(5);
  endtask

  task automatic expiry_trial(input string req, input int code, input int r);
    int t;
    do_reset();
    configure(code, r);
    bus_wr(2'd0, 16'hCCCC);
    t = timeout_of(r, code);
    ticks(t - 1);
    check(req, int'(wdog_rst_req), 0);
    ticks(1);
    check(req, int'(wdog_rst_req), 1);
  endtask

  initial begin
    #(4ns * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d;
    seed_init = $urandom(32'h1F2E3D4C);
    do_reset();

    // R1 reset values
    check("R1", int'(wdog_rst_req), 0);
    bus_rd(2'd1, d); check("R1", d, 0);
    bus_rd(2'd2, d); check("R1", d, 16'h0FFF);
    bus_rd(2'd3, d); check("R1", d, 0);

    // R3 locked writes ignored; a foreign key relocks
    bus_wr(2'd1, 16'h0003);
    bus_rd(2'd1, d); check("R3", d, 0);
    bus_wr(2'd0, 16'h5555);
    bus_wr(2'd0, 16'h1234);
    bus_wr(2'd2, 16'h0077);
    bus_rd(2'd2, d); check("R3", d, 16'h0FFF);

    // R2 field widths, R4 busy timing
    bus_wr(2'd0, 16'h5555);
    bus_wr(2'd2, 16'hF123);
    bus_rd(2'd2, d); check("R2", d, 16'h0123);
    bus_rd(2'd3, d); check("R4", d, 2);
    bus_rd(2'd0, d); check("R2", d, 0);
    // R5 write during busy is lost
    bus_wr(2'd2, 16'h0456);
    bus_rd(2'd2, d); check("R5", d, 16'h0123);
    ticks(4);
    bus_rd(2'd3, d); check("R4", d, 2);
    ticks(1);
    bus_rd(2'd3, d); check("R4", d, 0);
    bus_wr(2'd1, 16'h0005);
    bus_rd(2'd3, d); check("R4", d, 1);
    bus_rd(2'd1, d); check("R2", d, 5);
    ticks(5);
    bus_rd(2'd3, d); check("R4", d, 0);

    // R6 no start, no request
    do_reset();
    configure(0, 1);
    ticks(40);
    check("R6", int'(wdog_rst_req), 0);

    // R6 directed corner codes, including the clamp of codes 6 and 7
    expiry_trial("R6", 0, 3);
    expiry_trial("R6", 7, 2);
    expiry_trial("R6", 6, 1);
    expiry_trial("R6", 1, 0);
    for (int k = 0; k < 6; k++)
      expiry_trial("R6", int'($urandom % 8), 1 + int'($urandom % 6));

    // R7 refresh restarts the timeout
    do_reset();
    configure(0, 3);
    bus_wr(2'd0, 16'hCCCC);
    ticks(10);
    bus_wr(2'd0, 16'hAAAA);
    ticks(11);
    check("R7", int'(wdog_rst_req), 0);
    ticks(1);
    check("R7", int'(wdog_rst_req), 1);

    // R8 refresh in the same cycle as the final tick
    do_reset();
    configure(0, 2);
    bus_wr(2'd0, 16'hCCCC);
    ticks(7);
    @(negedge clk);
    slow_tick = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'hAAAA;
    @(negedge clk);
    slow_tick = 1'b0; reg_wr = 1'b0;
    check("R8", int'(wdog_rst_req), 0);
    ticks(7);
    check("R8", int'(wdog_rst_req), 0);
    ticks(1);
    check("R8", int'(wdog_rst_req), 1);

    // R10 other keys do not stop counting
    do_reset();
    configure(0, 2);
    bus_wr(2'd0, 16'hCCCC);
    ticks(3);
    bus_wr(2'd0, 16'h0000);
    bus_wr(2'd0, 16'h5555);
    ticks(4);
    check("R10", int'(wdog_rst_req), 0);
    ticks(1);
    check("R10", int'(wdog_rst_req), 1);

    // R11 forced reset: reload 1 then refresh
    do_reset();
    bus_wr(2'd0, 16'hCCCC);
    bus_wr(2'd0, 16'h5555);
    bus_wr(2'd2, 16'h0001);
    ticks(5);
    bus_wr(2'd0, 16'hAAAA);
    ticks(3);
    check("R11", int'(wdog_rst_req), 0);
    ticks(1);
    check("R11", int'(wdog_rst_req), 1);

    // R9 request sticks through keys and ticks
    bus_wr(2'd0, 16'hAAAA);
    bus_wr(2'd0, 16'h5555);
    ticks(10);
    check("R9", int'(wdog_rst_req), 1);
    do_reset();
    check("R9", int'(wdog_rst_req), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule